// File: doc/BRIEF.md
# Receive Path Phase Synchronisation Controller

This block keeps the phase state of two receive-path timing elements: a coarse mixer, whose phase is a 2-bit counter, and a clock divider, whose phase is a single bit. Each phase can be set in one of two ways. The first is an external synchronisation pulse, which loads a programmed phase value. The second is a software-owned control bit. A rising edge on that bit steps the mixer phase or flips the divider phase, with no synchronisation pulse involved.

Synchronisation can be switched off for each of four consumers: the mixer, the divider, the quadrature offset corrector and the quadrature gain/phase corrector. A consumer's own disable bit counts only while the global disable bit is also set. When synchronisation is in force for a consumer, a pulse produces a one-cycle "applied" strobe for it. The software stepping path of the mixer or the divider is open only when that element's synchronisation is off, which needs both the global and the element's own disable bit set.

All outputs are registered. Every result appears in the cycle after the clock edge that sampled its cause.

Top module: `rx_phase_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `mix_phase` and `div_phase` are 0 and all four strobes are 0. The stored copies of the step and flip bits are 0.
- R2: A block's synchronisation is in force unless both `glob_sync_off` and that block's own off bit are 1. A block off bit with `glob_sync_off` at 0 has no effect.
- R3: If mixer synchronisation is in force and `sync_in` is 1 at a clock edge, `mix_phase` equals `mix_phase_cfg` after that edge, and `mix_sync_stb` is 1 for exactly that next cycle.
- R4: If divider synchronisation is in force and `sync_in` is 1 at a clock edge, `div_phase` equals `div_phase_cfg` after that edge, and `div_sync_stb` is 1 for exactly that next cycle.
- R5: If mixer synchronisation is off, a clock edge where `mix_step` is 1 and was 0 at the previous edge adds 1 to `mix_phase`, modulo 4 (3 wraps to 0).
- R6: Holding `mix_step` or `div_flip` high steps the phase only once. A further step needs the bit to return to 0 and rise again.
- R7: A rising edge of `mix_step` while mixer synchronisation is in force leaves `mix_phase` unchanged.
- R8: If divider synchronisation is off, a rising edge of `div_flip` inverts `div_phase`. While divider synchronisation is in force, the edge leaves `div_phase` unchanged.
- R9: While a block's synchronisation is off, `sync_in` leaves its phase unchanged and its strobe stays 0.
- R10: `qofs_sync_stb` and `qgp_sync_stb` follow the rules of R2 and R9 for the quadrature offset and gain/phase blocks: one cycle high after a `sync_in` edge while that block's synchronisation is in force, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Synchronisation event, sampled each edge |
| glob_sync_off | input | 1 | Global synchronisation disable |
| mix_sync_off | input | 1 | Mixer synchronisation disable |
| div_sync_off | input | 1 | Divider synchronisation disable |
| qofs_sync_off | input | 1 | Quadrature offset synchronisation disable |
| qgp_sync_off | input | 1 | Quadrature gain/phase synchronisation disable |
| mix_phase_cfg | input | 2 | Mixer phase loaded on synchronisation |
| div_phase_cfg | input | 1 | Divider phase loaded on synchronisation |
| mix_step | input | 1 | Software mixer phase step bit (acts on rising edge) |
| div_flip | input | 1 | Software divider phase invert bit (acts on rising edge) |
| mix_phase | output | 2 | Current mixer phase |
| div_phase | output | 1 | Current divider phase |
| mix_sync_stb | output | 1 | Mixer synchronisation applied |
| div_sync_stb | output | 1 | Divider synchronisation applied |
| qofs_sync_stb | output | 1 | Quadrature offset synchronisation applied |
| qgp_sync_stb | output | 1 | Quadrature gain/phase synchronisation applied |

## Verification
Every output of this block is due exactly one cycle after the edge that samples its cause. This holds for a phase load from `sync_in`, a step or flip from a rising control bit, and each strobe. The bench drives all inputs at the falling edge and pushes the reference model's expected outputs for that cycle into a queue. The monitor pops one item a short delay after the next rising edge, so each comparison lands in the single cycle where the result must show. A held bit, a wrap from 3 to 0, and an off bit without the global disable are each checked in the cycles that follow the stimulus, where a wrong extra step would appear.

// File: rtl/rx_psync_pkg.sv
package rx_psync_pkg;
    localparam int NUM_BLK = 4;

    typedef enum logic [1:0] {
        BLK_MIX  = 2'd0,
        BLK_DIV  = 2'd1,
        BLK_QOFS = 2'd2,
        BLK_QGP  = 2'd3
    } blk_e;

    typedef logic [NUM_BLK-1:0] blk_vec_t;
endpackage

// File: rtl/rps_rise_det.sv
module rps_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = bits_i;
        rise_o    = bits_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rps_sync_gate.sv
module rps_sync_gate
    import rx_psync_pkg::*;
#(
    parameter int N = NUM_BLK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_i,
    input  logic         glob_off_i,
    input  logic [N-1:0] blk_off_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] apply_o,
    output logic [N-1:0] stb_o
);
    typedef struct packed {
        logic [N-1:0] stb;
    } state_t;

    state_t st_d, st_q;

    for (genvar g = 0; g < N; g++) begin : g_blk
        assign en_o[g]    = ~(glob_off_i & blk_off_i[g]);
        assign apply_o[g] = en_o[g] & sync_i;
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = apply_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb_o = st_q.stb;
endmodule

// File: rtl/rps_mix_phase.sv
module rps_mix_phase #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         apply_i,
    input  logic         rise_i,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] phase_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] phase;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (apply_i)
            st_d.phase = cfg_i;
        else if (!en_i && rise_i)
            st_d.phase = st_q.phase + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;
endmodule

// File: rtl/rps_div_phase.sv
module rps_div_phase #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         apply_i,
    input  logic         rise_i,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] phase_o
);
    typedef struct packed {
        logic [W-1:0] phase;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (apply_i)
            st_d.phase = cfg_i;
        else if (!en_i && rise_i)
            st_d.phase = ~st_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;
endmodule

// File: rtl/rx_phase_sync_ctrl.sv
module rx_phase_sync_ctrl
    import rx_psync_pkg::*;
#(
    parameter int MIX_W = 2,
    parameter int DIV_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             glob_sync_off,
    input  logic             mix_sync_off,
    input  logic             div_sync_off,
    input  logic             qofs_sync_off,
    input  logic             qgp_sync_off,
    input  logic [MIX_W-1:0] mix_phase_cfg,
    input  logic [DIV_W-1:0] div_phase_cfg,
    input  logic             mix_step,
    input  logic             div_flip,
    output logic [MIX_W-1:0] mix_phase,
    output logic [DIV_W-1:0] div_phase,
    output logic             mix_sync_stb,
    output logic             div_sync_stb,
    output logic             qofs_sync_stb,
    output logic             qgp_sync_stb
);
    localparam int NSW = 2;

    blk_vec_t        blk_off, blk_en, blk_apply, blk_stb;
    logic [NSW-1:0]  sw_bits, sw_rise;

    always_comb begin
        blk_off           = '0;
        blk_off[BLK_MIX]  = mix_sync_off;
        blk_off[BLK_DIV]  = div_sync_off;
        blk_off[BLK_QOFS] = qofs_sync_off;
        blk_off[BLK_QGP]  = qgp_sync_off;
    end

    assign sw_bits = {div_flip, mix_step};

    rps_sync_gate #(.N(NUM_BLK)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_in),
        .glob_off_i(glob_sync_off),
        .blk_off_i (blk_off),
        .en_o      (blk_en),
        .apply_o   (blk_apply),
        .stb_o     (blk_stb)
    );

    rps_rise_det #(.W(NSW)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .bits_i(sw_bits),
        .rise_o(sw_rise)
    );

    rps_mix_phase #(.W(MIX_W)) u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (blk_en[BLK_MIX]),
        .apply_i(blk_apply[BLK_MIX]),
        .rise_i (sw_rise[0]),
        .cfg_i  (mix_phase_cfg),
        .phase_o(mix_phase)
    );

    rps_div_phase #(.W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (blk_en[BLK_DIV]),
        .apply_i(blk_apply[BLK_DIV]),
        .rise_i (sw_rise[1]),
        .cfg_i  (div_phase_cfg),
        .phase_o(div_phase)
    );

    assign mix_sync_stb  = blk_stb[BLK_MIX];
    assign div_sync_stb  = blk_stb[BLK_DIV];
    assign qofs_sync_stb = blk_stb[BLK_QOFS];
    assign qgp_sync_stb  = blk_stb[BLK_QGP];
endmodule

// File: rtl/rps_sync_checker.sv
module rps_sync_checker #(
    parameter int MIX_W = 2,
    parameter int DIV_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_in,
    input logic             glob_sync_off,
    input logic             mix_sync_off,
    input logic             div_sync_off,
    input logic             qofs_sync_off,
    input logic             qgp_sync_off,
    input logic [MIX_W-1:0] mix_phase_cfg,
    input logic [DIV_W-1:0] div_phase_cfg,
    input logic             mix_step,
    input logic             div_flip,
    input logic [MIX_W-1:0] mix_phase,
    input logic [DIV_W-1:0] div_phase,
    input logic             mix_sync_stb,
    input logic             div_sync_stb,
    input logic             qofs_sync_stb,
    input logic             qgp_sync_stb
);
    logic step_prev, flip_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_prev <= 1'b0;
            flip_prev <= 1'b0;
        end else begin
            step_prev <= mix_step;
            flip_prev <= div_flip;
        end
    end

    logic mix_on, div_on, qofs_on, qgp_on, mix_up, div_up;
    assign mix_on  = !(glob_sync_off && mix_sync_off);
    assign div_on  = !(glob_sync_off && div_sync_off);
    assign qofs_on = !(glob_sync_off && qofs_sync_off);
    assign qgp_on  = !(glob_sync_off && qgp_sync_off);
    assign mix_up  = !mix_on && mix_step && !step_prev;
    assign div_up  = !div_on && div_flip && !flip_prev;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (mix_phase == '0 && div_phase == '0 && !mix_sync_stb && !qgp_sync_stb));

    assert_mix_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mix_on && sync_in) |=> (mix_phase == $past(mix_phase_cfg) && mix_sync_stb));

    assert_div_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on && sync_in) |=> (div_phase == $past(div_phase_cfg) && div_sync_stb));

    assert_mix_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mix_up |=> (mix_phase == MIX_W'($past(mix_phase) + 1)));

    assert_mix_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mix_on && sync_in) && !mix_up) |=> $stable(mix_phase));

    assert_div_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_up |=> (div_phase == ~$past(div_phase)));

    assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(div_on && sync_in) && !div_up) |=> $stable(div_phase));

    assert_stb_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_in && mix_on) |=> !mix_sync_stb);

    assert_div_stb_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_in && div_on) |=> !div_sync_stb);

    assert_qofs_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && qofs_on) |=> qofs_sync_stb);

    assert_qofs_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_in && qofs_on) |=> !qofs_sync_stb);

    assert_qgp_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && qgp_on) |=> qgp_sync_stb);

    assert_qgp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_in && qgp_on) |=> !qgp_sync_stb);
endmodule

bind rx_phase_sync_ctrl rps_sync_checker #(.MIX_W(MIX_W), .DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_in      (sync_in),
    .glob_sync_off(glob_sync_off),
    .mix_sync_off (mix_sync_off),
    .div_sync_off (div_sync_off),
    .qofs_sync_off(qofs_sync_off),
    .qgp_sync_off (qgp_sync_off),
    .mix_phase_cfg(mix_phase_cfg),
    .div_phase_cfg(div_phase_cfg),
    .mix_step     (mix_step),
    .div_flip     (div_flip),
    .mix_phase    (mix_phase),
    .div_phase    (div_phase),
    .mix_sync_stb (mix_sync_stb),
    .div_sync_stb (div_sync_stb),
    .qofs_sync_stb(qofs_sync_stb),
    .qgp_sync_stb (qgp_sync_stb)
);

// File: tb/tb_rx_phase_sync_ctrl.sv
`timescale 1ns/1ps
module tb_rx_phase_sync_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       glob_sync_off = 1'b0, mix_sync_off = 1'b0, div_sync_off = 1'b0;
    logic       qofs_sync_off = 1'b0, qgp_sync_off = 1'b0;
    logic [1:0] mix_phase_cfg = 2'd0;
    logic       div_phase_cfg = 1'b0;
    logic       mix_step = 1'b0, div_flip = 1'b0;
    logic [1:0] mix_phase;
    logic       div_phase, mix_sync_stb, div_sync_stb, qofs_sync_stb, qgp_sync_stb;

    always #2.5 clk = ~clk;

    rx_phase_sync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .glob_sync_off(glob_sync_off), .mix_sync_off(mix_sync_off),
        .div_sync_off(div_sync_off), .qofs_sync_off(qofs_sync_off),
        .qgp_sync_off(qgp_sync_off), .mix_phase_cfg(mix_phase_cfg),
        .div_phase_cfg(div_phase_cfg), .mix_step(mix_step), .div_flip(div_flip),
        .mix_phase(mix_phase), .div_phase(div_phase),
        .mix_sync_stb(mix_sync_stb), .div_sync_stb(div_sync_stb),
        .qofs_sync_stb(qofs_sync_stb), .qgp_sync_stb(qgp_sync_stb)
    );

    typedef struct {
        logic [1:0] mix;
        logic       div;
        logic [3:0] stb;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    logic [1:0] m_mix = 0;
    logic       m_div = 0, m_pstep = 0, m_pflip = 0;

    // Driver: called at a falling edge; applies inputs, models the next edge, pushes expectation.
    task automatic cyc(input string tag, input logic s, input logic st, input logic fl);
        exp_t e;
        logic en_m, en_d, en_o, en_g;
        sync_in = s; mix_step = st; div_flip = fl;
        if (!rst_n) begin
            m_mix = 0; m_div = 0; m_pstep = 0; m_pflip = 0;
            e.stb = 4'b0;
        end else begin
            en_m = !(glob_sync_off && mix_sync_off);
            en_d = !(glob_sync_off && div_sync_off);
            en_o = !(glob_sync_off && qofs_sync_off);
            en_g = !(glob_sync_off && qgp_sync_off);
            if (en_m && s) m_mix = mix_phase_cfg;
            else if (!en_m && st && !m_pstep) m_mix = m_mix + 2'd1;
            if (en_d && s) m_div = div_phase_cfg;
            else if (!en_d && fl && !m_pflip) m_div = ~m_div;
            m_pstep = st; m_pflip = fl;
            e.stb = {en_g && s, en_o && s, en_d && s, en_m && s};
        end
        e.mix = m_mix; e.div = m_div; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: samples one item per cycle, just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [3:0] got;
                e = exp_q.pop_front();
                got = {qgp_sync_stb, qofs_sync_stb, div_sync_stb, mix_sync_stb};
                n_run++;
                if (mix_phase !== e.mix || div_phase !== e.div || got !== e.stb) begin
                    n_fail++;
                    $display("FAIL %s: mix=%0d div=%0d stb=%b expected mix=%0d div=%0d stb=%b",
                             e.tag, mix_phase, div_phase, got, e.mix, e.div, e.stb);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc("R1 reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc("R1 after reset", 1'b0, 1'b0, 1'b0);

        // R3/R4: synced load with all syncing on
        mix_phase_cfg = 2'd2; div_phase_cfg = 1'b1;
        cyc("R3 R4 sync load", 1'b1, 1'b0, 1'b0);
        cyc("R3 strobe one cycle", 1'b0, 1'b0, 1'b0);

        // R2: block off without global has no effect
        mix_sync_off = 1'b1; div_sync_off = 1'b1; mix_phase_cfg = 2'd1; div_phase_cfg = 1'b0;
        cyc("R2 block off only", 1'b1, 1'b0, 1'b0);
        cyc("R7 step while synced", 1'b0, 1'b1, 1'b1);
        cyc("R7 R8 no change", 1'b0, 1'b0, 1'b0);

        // R9: global+block off, sync ignored by mixer and divider
        glob_sync_off = 1'b1; mix_phase_cfg = 2'd3; div_phase_cfg = 1'b1;
        cyc("R9 sync ignored", 1'b1, 1'b0, 1'b0);
        cyc("R9 quiet", 1'b0, 1'b0, 1'b0);

        // R5/R6: stepping and wrap
        cyc("R5 step 1->2", 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) cyc("R6 held high", 1'b0, 1'b1, 1'b0);
        cyc("R6 clear", 1'b0, 1'b0, 1'b0);
        cyc("R5 step 2->3", 1'b0, 1'b1, 1'b0);
        cyc("R6 clear", 1'b0, 1'b0, 1'b0);
        cyc("R5 wrap 3->0", 1'b0, 1'b1, 1'b0);
        cyc("R5 after wrap", 1'b0, 1'b0, 1'b0);

        // R8: divider flip
        cyc("R8 flip", 1'b0, 1'b0, 1'b1);
        cyc("R6 flip held", 1'b0, 1'b0, 1'b1);
        cyc("R8 clear", 1'b0, 1'b0, 1'b0);
        cyc("R8 flip again", 1'b0, 1'b0, 1'b1);
        cyc("R8 clear", 1'b0, 1'b0, 1'b0);

        // R8/R4: divider synced again, flip ignored, mixer still off
        div_sync_off = 1'b0; div_phase_cfg = 1'b0;
        cyc("R8 flip ignored synced", 1'b0, 1'b0, 1'b1);
        cyc("R4 R9 mixed sync", 1'b1, 1'b1, 1'b0);
        cyc("R4 quiet", 1'b0, 1'b0, 1'b0);

        // R10: quadrature strobes
        qofs_sync_off = 1'b1;
        cyc("R10 qofs off", 1'b1, 1'b0, 1'b0);
        qofs_sync_off = 1'b0; qgp_sync_off = 1'b1;
        cyc("R10 qgp off", 1'b1, 1'b0, 1'b0);
        glob_sync_off = 1'b0;
        cyc("R10 R2 global on", 1'b1, 1'b0, 1'b0);
        cyc("R10 quiet", 1'b0, 1'b0, 1'b0);

        // back-to-back sync pulses
        mix_phase_cfg = 2'd1;
        cyc("R3 back to back a", 1'b1, 1'b0, 1'b0);
        mix_phase_cfg = 2'd2;
        cyc("R3 back to back b", 1'b1, 1'b0, 1'b0);
        cyc("R3 end", 1'b0, 1'b0, 1'b0);
        cyc("R3 idle", 1'b0, 1'b0, 1'b0);

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule